// File: doc/BRIEF.md
# Out-of-order issue window

This block is a small buffer in the issue stage of a pipeline. It sits between decode and the functional units. Decode can offer one instruction per cycle. Each instruction names a functional unit class, a destination register and two source registers. The window takes the instruction only when a slot is free and the instruction does not conflict with the work already held. There is no register renaming, so two conflicts block entry. The first is a destination that already has a write pending. The second is a destination that a held instruction still has to read.

Every cycle the window picks at most one held instruction and dispatches it to its unit. The instruction must have no pending source writes, and its unit must not be busy. When several qualify, the oldest goes first. Younger instructions may pass older ones that are still waiting. The functional unit latches the operands at dispatch, so the slot is released on that edge. Writeback reports a finished register, which clears its pending-write bit and wakes any instruction waiting on it.

Top module: `issue_window`

## Requirements
- R1: After reset the window holds nothing: `disp_valid_o` is 0 and `in_ready_o` is 1 for any offered instruction.
- R2: An offered instruction is accepted on the clock edge where `in_valid_i` and `in_ready_o` are both 1. Up to NUM_ENTRIES instructions can be held at once. While all slots are occupied, `in_ready_o` is 0.
- R3: An instruction whose destination already has a pending write is refused. It stays refused through the cycle in which that register's writeback is presented, and can be accepted from the next cycle on.
- R4: An instruction whose destination equals either source of any held instruction is refused. This lasts until that instruction has left the window.
- R5: A held instruction with a source whose write is pending is not dispatched. It becomes dispatchable in the cycle after the writeback of that register.
- R6: At most one instruction is dispatched per cycle. Among the dispatchable instructions, the earliest accepted one is chosen.
- R7: A younger dispatchable instruction is dispatched while an older one is still waiting on a source.
- R8: An instruction is not dispatched in a cycle in which `unit_busy_i` has the bit for its unit class set.
- R9: A slot is freed on the edge at which its instruction is dispatched. A full window therefore raises `in_ready_o` in the next cycle, and not in the dispatch cycle itself.
- R10: An instruction that reads its own destination register is not held back by its own pending write.
- R11: During dispatch, `disp_unit_o`, `disp_dst_o`, `disp_src1_o` and `disp_src2_o` carry the fields of the dispatched instruction. The acceptance of an instruction sets the pending-write bit of its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decode offers an instruction |
| in_unit_i | input | UNIT_W | Functional unit class of the offered instruction |
| in_dst_i | input | REG_W | Destination register |
| in_src1_i | input | REG_W | First source register |
| in_src2_i | input | REG_W | Second source register |
| in_ready_o | output | 1 | Offered instruction can be accepted this cycle |
| unit_busy_i | input | NUM_UNITS | One busy bit per functional unit class |
| disp_valid_o | output | 1 | An instruction is dispatched this cycle |
| disp_unit_o | output | UNIT_W | Unit class of the dispatched instruction |
| disp_dst_o | output | REG_W | Destination of the dispatched instruction |
| disp_src1_o | output | REG_W | First source of the dispatched instruction |
| disp_src2_o | output | REG_W | Second source of the dispatched instruction |
| wb_valid_i | input | 1 | A register write completes |
| wb_reg_i | input | REG_W | Register written back |

## Verification
Some properties are checked on every cycle:
- at most one grant per cycle;
- no dispatch to a busy unit;
- no dispatch with a foreign pending source;
- slot release on dispatch;
- refusal when the window is full or the destination is already pending;
- pending bits set on acceptance and cleared on writeback.

Other behaviour shows only over a sequence of cycles, so only the directed scenarios can show it:
- oldest-first choice among several ready entries;
- a younger entry overtaking a stalled older one;
- the exact cycle in which a writeback wakes a waiter;
- a WAR block that lifts only after the reader leaves;
- the one-cycle delay before a freed slot accepts.

// File: rtl/iw_pkg.sv
package iw_pkg;
  localparam int DEF_ENTRIES = 4;
  localparam int DEF_REGS    = 16;
  localparam int DEF_UNITS   = 4;

  function automatic int clog2_min1(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/iw_pend_table.sv
module iw_pend_table #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_i,
  input  logic [REG_W-1:0]    set_reg_i,
  input  logic                clr_i,
  input  logic [REG_W-1:0]    clr_reg_i,
  output logic [NUM_REGS-1:0] pend_o
);
  logic [NUM_REGS-1:0] pend_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[r] <= 1'b0;
      end else if (set_i && set_reg_i == REG_W'(r)) begin
        pend_q[r] <= 1'b1;
      end else if (clr_i && clr_reg_i == REG_W'(r)) begin
        pend_q[r] <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;

  AST_SET_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_q[$past(set_reg_i)]); // R11
  AST_CLR_ON_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && pend_q[clr_reg_i] && !(set_i && set_reg_i == clr_reg_i))
      |=> !pend_q[$past(clr_reg_i)]); // R5
endmodule

// File: rtl/iw_entry.sv
module iw_entry #(
  parameter int NUM_UNITS = 4,
  parameter int UNIT_W    = 2,
  parameter int REG_W     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [UNIT_W-1:0]    load_unit_i,
  input  logic [REG_W-1:0]     load_dst_i,
  input  logic [REG_W-1:0]     load_src1_i,
  input  logic [REG_W-1:0]     load_src2_i,
  input  logic                 load_src1_rdy_i,
  input  logic                 load_src2_rdy_i,
  input  logic                 wb_valid_i,
  input  logic [REG_W-1:0]     wb_reg_i,
  input  logic [NUM_UNITS-1:0] unit_busy_i,
  input  logic                 grant_i,
  output logic                 valid_o,
  output logic [UNIT_W-1:0]    unit_o,
  output logic [REG_W-1:0]     dst_o,
  output logic [REG_W-1:0]     src1_o,
  output logic [REG_W-1:0]     src2_o,
  output logic                 ready_o
);
  logic              valid_q;
  logic [UNIT_W-1:0] unit_q;
  logic [REG_W-1:0]  dst_q, src1_q, src2_q;
  logic              s1_rdy_q, s2_rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      unit_q   <= '0;
      dst_q    <= '0;
      src1_q   <= '0;
      src2_q   <= '0;
      s1_rdy_q <= 1'b0;
      s2_rdy_q <= 1'b0;
    end else if (load_i) begin
      valid_q  <= 1'b1;
      unit_q   <= load_unit_i;
      dst_q    <= load_dst_i;
      src1_q   <= load_src1_i;
      src2_q   <= load_src2_i;
      s1_rdy_q <= load_src1_rdy_i;
      s2_rdy_q <= load_src2_rdy_i;
    end else begin
      if (grant_i) valid_q <= 1'b0;
      if (wb_valid_i && wb_reg_i == src1_q) s1_rdy_q <= 1'b1;
      if (wb_valid_i && wb_reg_i == src2_q) s2_rdy_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign unit_o  = unit_q;
  assign dst_o   = dst_q;
  assign src1_o  = src1_q;
  assign src2_o  = src2_q;
  assign ready_o = valid_q && s1_rdy_q && s2_rdy_q && !unit_busy_i[unit_q];

  AST_LOAD_INTO_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_q); // R2
  AST_FREE_ON_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && !load_i) |=> !valid_q); // R9
  AST_GRANT_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> (valid_q && !unit_busy_i[unit_q])); // R8
endmodule

// File: rtl/iw_age_select.sv
module iw_age_select #(
  parameter int NUM_ENTRIES = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_ENTRIES-1:0] ins_i,
  input  logic [NUM_ENTRIES-1:0] valid_i,
  input  logic [NUM_ENTRIES-1:0] ready_i,
  output logic [NUM_ENTRIES-1:0] grant_o
);
  // older_q[i][j]: entry i was accepted before entry j
  logic [NUM_ENTRIES-1:0] older_q [NUM_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ENTRIES; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        for (int j = 0; j < NUM_ENTRIES; j++) begin
          if (ins_i[i])      older_q[i][j] <= 1'b0;
          else if (ins_i[j]) older_q[i][j] <= valid_i[i];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      grant_o[i] = ready_i[i];
      for (int j = 0; j < NUM_ENTRIES; j++) begin
        if (j != i && ready_i[j] && older_q[j][i]) grant_o[i] = 1'b0;
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R6
  AST_READY_GETS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ready_i) |-> (|grant_o)); // R6
endmodule

// File: rtl/issue_window.sv
module issue_window
  import iw_pkg::*;
#(
  parameter int NUM_ENTRIES = DEF_ENTRIES,
  parameter int NUM_REGS    = DEF_REGS,
  parameter int NUM_UNITS   = DEF_UNITS,
  localparam int REG_W      = clog2_min1(NUM_REGS),
  localparam int UNIT_W     = clog2_min1(NUM_UNITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [UNIT_W-1:0]    in_unit_i,
  input  logic [REG_W-1:0]     in_dst_i,
  input  logic [REG_W-1:0]     in_src1_i,
  input  logic [REG_W-1:0]     in_src2_i,
  output logic                 in_ready_o,
  input  logic [NUM_UNITS-1:0] unit_busy_i,
  output logic                 disp_valid_o,
  output logic [UNIT_W-1:0]    disp_unit_o,
  output logic [REG_W-1:0]     disp_dst_o,
  output logic [REG_W-1:0]     disp_src1_o,
  output logic [REG_W-1:0]     disp_src2_o,
  input  logic                 wb_valid_i,
  input  logic [REG_W-1:0]     wb_reg_i
);
  logic [NUM_ENTRIES-1:0] valid, ready, grant, ins_sel, load;
  logic [UNIT_W-1:0]      unit_q [NUM_ENTRIES];
  logic [REG_W-1:0]       dst_q  [NUM_ENTRIES];
  logic [REG_W-1:0]       src1_q [NUM_ENTRIES];
  logic [REG_W-1:0]       src2_q [NUM_ENTRIES];
  logic [NUM_REGS-1:0]    pend;
  logic                   slot_free, war_hit, accept;
  logic                   src1_rdy, src2_rdy;

  // lowest free slot
  always_comb begin
    ins_sel   = '0;
    slot_free = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!valid[i] && !slot_free) begin
        ins_sel[i] = 1'b1;
        slot_free  = 1'b1;
      end
    end
  end

  // conservative WAR: any held source, ready or not
  always_comb begin
    war_hit = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (valid[i] && (src1_q[i] == in_dst_i || src2_q[i] == in_dst_i)) war_hit = 1'b1;
    end
  end

  assign in_ready_o = slot_free && !pend[in_dst_i] && !war_hit;
  assign accept     = in_valid_i && in_ready_o;
  assign load       = accept ? ins_sel : '0;

  // snapshot before own destination is marked, so self-reads never stall
  assign src1_rdy = !pend[in_src1_i] || (wb_valid_i && wb_reg_i == in_src1_i);
  assign src2_rdy = !pend[in_src2_i] || (wb_valid_i && wb_reg_i == in_src2_i);

  iw_pend_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (accept),
    .set_reg_i (in_dst_i),
    .clr_i     (wb_valid_i),
    .clr_reg_i (wb_reg_i),
    .pend_o    (pend)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    iw_entry #(.NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W), .REG_W(REG_W)) u_ent (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .load_i          (load[g]),
      .load_unit_i     (in_unit_i),
      .load_dst_i      (in_dst_i),
      .load_src1_i     (in_src1_i),
      .load_src2_i     (in_src2_i),
      .load_src1_rdy_i (src1_rdy),
      .load_src2_rdy_i (src2_rdy),
      .wb_valid_i      (wb_valid_i),
      .wb_reg_i        (wb_reg_i),
      .unit_busy_i     (unit_busy_i),
      .grant_i         (grant[g]),
      .valid_o         (valid[g]),
      .unit_o          (unit_q[g]),
      .dst_o           (dst_q[g]),
      .src1_o          (src1_q[g]),
      .src2_o          (src2_q[g]),
      .ready_o         (ready[g])
    );
  end

  iw_age_select #(.NUM_ENTRIES(NUM_ENTRIES)) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ins_i   (load),
    .valid_i (valid),
    .ready_i (ready),
    .grant_o (grant)
  );

  always_comb begin
    disp_unit_o = '0;
    disp_dst_o  = '0;
    disp_src1_o = '0;
    disp_src2_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (grant[i]) begin
        disp_unit_o = disp_unit_o | unit_q[i];
        disp_dst_o  = disp_dst_o  | dst_q[i];
        disp_src1_o = disp_src1_o | src1_q[i];
        disp_src2_o = disp_src2_o | src2_q[i];
      end
    end
  end

  assign disp_valid_o = |grant;

  AST_FULL_REFUSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid) |-> !in_ready_o); // R2
  AST_WAW_REFUSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend[in_dst_i] |-> !in_ready_o); // R3
  AST_DISP_UNIT_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> !unit_busy_i[disp_unit_o]); // R8
  AST_DISP_SRCS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> ((!pend[disp_src1_o] || disp_src1_o == disp_dst_o) &&
                      (!pend[disp_src2_o] || disp_src2_o == disp_dst_o))); // R5
  AST_DISP_DST_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> pend[disp_dst_o]); // R11
endmodule

// File: tb/issue_window_bench.sv
`timescale 1ns/1ps
module issue_window_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_unit = '0;
  logic [3:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic       in_ready;
  logic [3:0] busy = '0;
  logic       disp_valid;
  logic [1:0] disp_unit;
  logic [3:0] disp_dst, disp_src1, disp_src2;
  logic       wb_valid = 1'b0;
  logic [3:0] wb_reg = '0;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  issue_window u_issue_window (
    .clk_i (clk), .rst_ni (rst_n),
    .in_valid_i (in_valid), .in_unit_i (in_unit), .in_dst_i (in_dst),
    .in_src1_i (in_src1), .in_src2_i (in_src2), .in_ready_o (in_ready),
    .unit_busy_i (busy),
    .disp_valid_o (disp_valid), .disp_unit_o (disp_unit), .disp_dst_o (disp_dst),
    .disp_src1_o (disp_src1), .disp_src2_o (disp_src2),
    .wb_valid_i (wb_valid), .wb_reg_i (wb_reg)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one cycle after the falling edge, let outputs settle
  task automatic cyc(input logic iv, input logic [1:0] u, input logic [3:0] d,
                     input logic [3:0] s1, input logic [3:0] s2,
                     input logic wv, input logic [3:0] wr, input logic [3:0] b);
    @(negedge clk);
    in_valid = iv; in_unit = u; in_dst = d; in_src1 = s1; in_src2 = s2;
    wb_valid = wv; wb_reg = wr; busy = b;
    #1;
  endtask

  task automatic nop(input logic [3:0] b);
    cyc(1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 1'b0, 4'd0, b);
  endtask

  task automatic wb(input logic [3:0] r);
    cyc(1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 1'b1, r, 4'd0);
  endtask

  task automatic chk_disp(input string req, input logic v, input logic [3:0] d);
    chk(req, "disp_valid", int'(disp_valid), int'(v));
    if (v) chk(req, "disp_dst", int'(disp_dst), int'(d));
  endtask

  task automatic t_reset;
    nop(4'd0);
    chk("R1", "in_ready after reset", int'(in_ready), 1);
    chk("R1", "disp_valid after reset", int'(disp_valid), 0);
  endtask

  task automatic t_raw_wake;
    cyc(1'b1, 2'd0, 4'd1, 4'd2, 4'd3, 1'b0, 4'd0, 4'd0);          // A
    chk("R2", "accept A", int'(in_ready), 1);
    cyc(1'b1, 2'd1, 4'd4, 4'd1, 4'd5, 1'b0, 4'd0, 4'd0);          // B reads r1
    chk_disp("R11", 1'b1, 4'd1);
    chk("R11", "disp_unit", int'(disp_unit), 0);
    chk("R11", "disp_src1", int'(disp_src1), 2);
    chk("R11", "disp_src2", int'(disp_src2), 3);
    nop(4'd0);
    chk_disp("R5", 1'b0, 4'd0);
    wb(4'd1);
    chk_disp("R5", 1'b0, 4'd0);                                     // wake takes an edge
    nop(4'd0);
    chk_disp("R5", 1'b1, 4'd4);
    chk("R11", "disp_src1 B", int'(disp_src1), 1);
    wb(4'd4);
    chk_disp("R6", 1'b0, 4'd0);
  endtask

  task automatic t_oldest_busy;
    cyc(1'b1, 2'd2, 4'd6, 4'd0, 4'd0, 1'b0, 4'd0, 4'b0100);
    cyc(1'b1, 2'd2, 4'd7, 4'd0, 4'd0, 1'b0, 4'd0, 4'b0100);
    chk_disp("R8", 1'b0, 4'd0);
    nop(4'b0100);
    chk_disp("R8", 1'b0, 4'd0);
    nop(4'd0);
    chk_disp("R6", 1'b1, 4'd6);
    nop(4'd0);
    chk_disp("R6", 1'b1, 4'd7);
    wb(4'd6);
    chk_disp("R6", 1'b0, 4'd0);
    wb(4'd7);
  endtask

  task automatic t_overtake;
    cyc(1'b1, 2'd3, 4'd9, 4'd0, 4'd0, 1'b0, 4'd0, 4'd0);          // W writes r9
    cyc(1'b1, 2'd0, 4'd8, 4'd9, 4'd0, 1'b0, 4'd0, 4'd0);          // P reads r9
    chk_disp("R6", 1'b1, 4'd9);
    cyc(1'b1, 2'd1, 4'd10, 4'd0, 4'd0, 1'b0, 4'd0, 4'd0);         // Q independent
    chk_disp("R5", 1'b0, 4'd0);
    nop(4'd0);
    chk_disp("R7", 1'b1, 4'd10);
    wb(4'd9);
    chk_disp("R7", 1'b0, 4'd0);
    nop(4'd0);
    chk_disp("R7", 1'b1, 4'd8);
    wb(4'd8);
    wb(4'd10);
  endtask

  task automatic t_waw;
    cyc(1'b1, 2'd0, 4'd11, 4'd0, 4'd0, 1'b0, 4'd0, 4'd0);
    cyc(1'b1, 2'd1, 4'd11, 4'd1, 4'd1, 1'b0, 4'd0, 4'd0);
    chk("R3", "refuse pending dst", int'(in_ready), 0);
    chk_disp("R3", 1'b1, 4'd11);
    cyc(1'b1, 2'd1, 4'd11, 4'd1, 4'd1, 1'b0, 4'd0, 4'd0);
    chk("R3", "still refused", int'(in_ready), 0);
    chk_disp("R3", 1'b0, 4'd0);
    cyc(1'b1, 2'd1, 4'd11, 4'd1, 4'd1, 1'b1, 4'd11, 4'd0);
    chk("R3", "refused in wb cycle", int'(in_ready), 0);
    cyc(1'b1, 2'd1, 4'd11, 4'd1, 4'd1, 1'b0, 4'd0, 4'd0);
    chk("R3", "accepted after wb", int'(in_ready), 1);
    nop(4'd0);
    chk_disp("R3", 1'b1, 4'd11);
    chk("R11", "disp_unit second", int'(disp_unit), 1);
    nop(4'd0);
    chk_disp("R3", 1'b0, 4'd0);
    wb(4'd11);
  endtask

  task automatic t_war;
    cyc(1'b1, 2'd0, 4'd12, 4'd0, 4'd0, 1'b0, 4'd0, 4'd0);         // writes r12
    cyc(1'b1, 2'd1, 4'd13, 4'd12, 4'd0, 1'b0, 4'd0, 4'd0);        // R reads r12, r0
    chk_disp("R6", 1'b1, 4'd12);
    cyc(1'b1, 2'd2, 4'd0, 4'd1, 4'd1, 1'b0, 4'd0, 4'd0);          // writes r0
    chk("R4", "refuse WAR", int'(in_ready), 0);
    cyc(1'b1, 2'd2, 4'd0, 4'd1, 4'd1, 1'b1, 4'd12, 4'd0);
    chk("R4", "refuse WAR in wb cycle", int'(in_ready), 0);
    cyc(1'b1, 2'd2, 4'd0, 4'd1, 4'd1, 1'b0, 4'd0, 4'd0);
    chk_disp("R4", 1'b1, 4'd13);
    chk("R4", "refuse while reader dispatches", int'(in_ready), 0);
    cyc(1'b1, 2'd2, 4'd0, 4'd1, 4'd1, 1'b0, 4'd0, 4'd0);
    chk("R4", "accept after reader left", int'(in_ready), 1);
    nop(4'd0);
    chk_disp("R4", 1'b1, 4'd0);
    wb(4'd13);
    wb(4'd0);
  endtask

  task automatic t_full;
    for (int k = 1; k <= 4; k++) begin
      cyc(1'b1, 2'd0, 4'(k), 4'd0, 4'd0, 1'b0, 4'd0, 4'hF);
      chk("R2", "accept while filling", int'(in_ready), 1);
    end
    cyc(1'b1, 2'd0, 4'd5, 4'd0, 4'd0, 1'b0, 4'd0, 4'hF);
    chk("R2", "refuse when full", int'(in_ready), 0);
    cyc(1'b1, 2'd0, 4'd5, 4'd0, 4'd0, 1'b0, 4'd0, 4'd0);
    chk_disp("R9", 1'b1, 4'd1);
    chk("R9", "full during dispatch", int'(in_ready), 0);
    cyc(1'b1, 2'd0, 4'd5, 4'd0, 4'd0, 1'b0, 4'd0, 4'd0);
    chk("R9", "slot free next cycle", int'(in_ready), 1);
    chk_disp("R6", 1'b1, 4'd2);
    nop(4'd0);
    chk_disp("R6", 1'b1, 4'd3);
    nop(4'd0);
    chk_disp("R6", 1'b1, 4'd4);
    nop(4'd0);
    chk_disp("R6", 1'b1, 4'd5);
    for (int k = 1; k <= 5; k++) wb(4'(k));
  endtask

  task automatic t_self_read;
    cyc(1'b1, 2'd1, 4'd14, 4'd14, 4'd14, 1'b0, 4'd0, 4'd0);
    chk("R10", "accept self reader", int'(in_ready), 1);
    nop(4'd0);
    chk_disp("R10", 1'b1, 4'd14);
    wb(4'd14);
    chk_disp("R10", 1'b0, 4'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_raw_wake();
    t_oldest_busy();
    t_overtake();
    t_waw();
    t_war();
    t_full();
    t_self_read();
    nop(4'd0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog: cycles %0d expected below %0d", 20000, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule